// File: doc/BRIEF.md
# Fault-Injectable Single-Port Bit RAM

This block is a small synchronous single-port memory with one bit per address. At runtime it can be told to behave like a defective part, so that a memory self-test engine or a march-algorithm sequencer can be checked against known faults. It can also act as an ideal memory. At most one fault is active at a time. A fault is described by four things: a fault kind, a victim cell, an aggressor cell, and up to three single-bit qualifiers. The qualifiers are a forced value, an aggressor edge direction and an aggressor state.

The memory side has an address, a write strobe with its data bit, and a read strobe. Read data is registered. The fault description is sampled only on cycles with no memory access, so a fault never changes in the middle of an operation. Where a fault makes a read unpredictable, the returned bit is taken from a free-running pseudo-random sequence, so every simulation run repeats exactly. Victim and aggressor are assumed to be different cells for every coupling, bridging and decoder kind.

Top module: `flt_ram_top`

## Requirements
- R1: Synchronous active-low reset clears every cell to 0, clears the read data output to 0, and selects fault-free operation.
- R2: The read data output takes a new value only at the clock edge that ends a cycle with the read strobe high, and holds its value otherwise. When read and write hit the same cell in the same cycle, the value stored before the write is returned.
- R3: Fault kind code 0 gives ideal storage: every read returns the last value written to that address.
- R4: The fault settings are loaded only at the end of a cycle in which neither strobe is high, and they act from the next cycle onward. Settings presented during an access cycle are ignored.
- R5: Kind 1 (stuck cell): a read of the victim returns the forced value, whatever has been written to it.
- R6: Kind 2 (transition): a write of the forced value into the victim while the victim holds the opposite value leaves the victim unchanged. A write in the other direction succeeds.
- R7: Kind 3 (inverting coupling): a write that changes the stored aggressor value in the selected direction inverts the victim. The edge bit is 1 for 0-to-1 and 0 for 1-to-0. Writes that do not change the aggressor, or that change it the other way, leave the victim alone.
- R8: Kind 4 (forcing coupling): the same aggressor trigger as in R7 sets the victim to the forced value.
- R9: Kind 5 (state coupling): while the stored aggressor value equals the state bit, a read of the victim returns the forced value. Otherwise it returns the stored victim value.
- R10: Kinds 6 and 7 (bridge): a read of either the victim or the aggressor returns the AND (kind 6) or the OR (kind 7) of both stored values. Other addresses read normally.
- R11: Kind 8 (swapped decode): a write to the victim address is stored in the aggressor cell, and a write to the aggressor address is stored in the victim cell. A read of the aggressor returns the aggressor cell. A read of the victim returns a bit of a free-running pseudo-random sequence that takes both values over time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | input | ADDR_W | Cell address for read and write |
| mem_we | input | 1 | Write strobe |
| mem_wdata | input | 1 | Write data bit |
| mem_re | input | 1 | Read strobe |
| mem_rdata | output | 1 | Registered read data |
| flt_kind | input | 4 | Fault kind code (0 to 8) |
| flt_victim | input | ADDR_W | Victim cell address |
| flt_aggr | input | ADDR_W | Aggressor cell address |
| flt_val | input | 1 | Forced, stuck or blocked-target value |
| flt_rise | input | 1 | Aggressor trigger edge: 1 for 0-to-1, 0 for 1-to-0 |
| flt_cond | input | 1 | Aggressor state that activates state coupling |

## Verification
The hardest situations to reach are the coupling triggers. They depend on the stored aggressor value before the write, so the stimulus first sets up aggressor and victim contents while the memory is fault-free or under an unrelated fault. It then switches the fault in during an idle cycle and issues writes that change, repeat and reverse the aggressor value, reading the victim after each one. The swapped-decode case is checked by moving to fault-free operation afterwards and reading both cells directly. The pseudo-random read is checked by many back-to-back victim reads that must produce both values.

// File: rtl/flt_ram_pkg.sv
// Package: shared fault kind encoding and fault qualifier bundle for the
// fault-injectable RAM. Assumes kinds 9..15 are never used by callers.
package flt_ram_pkg;

    typedef enum logic [3:0] {
        FK_NONE    = 4'd0,
        FK_STUCK   = 4'd1,
        FK_TRANS   = 4'd2,
        FK_CPL_INV = 4'd3,
        FK_CPL_FRC = 4'd4,
        FK_CPL_ST  = 4'd5,
        FK_BR_AND  = 4'd6,
        FK_BR_OR   = 4'd7,
        FK_DEC_SWP = 4'd8
    } fault_kind_e;

    typedef struct packed {
        fault_kind_e kind;
        logic        val;
        logic        rise;
        logic        cond;
    } fault_sel_t;

endpackage

// File: rtl/flt_ram_lfsr.sv
// Module: free-running maximal-length Fibonacci LFSR. It supplies the
// repeatable "unpredictable" bit returned by reads of an unreachable cell.
// Assumes SEED is non-zero and TAPS describes a maximal polynomial for W.
module flt_ram_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    output logic rnd_bit
);
    logic [W-1:0] state_q;
    logic         fb;

    // feedback is the parity of the tapped bits
    assign fb = ^(state_q & TAPS);

    // advance the sequence every cycle, reseed on reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {state_q[W-2:0], fb};
    end

    assign rnd_bit = state_q[W-1];

    // an all-zero state would freeze the random read value
    assert_lfsr_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/flt_ram_cfg.sv
// Module: fault-setting register. It captures kind, cell addresses and
// qualifiers only on idle cycles, so a fault never changes during an access.
// Assumes busy is high in every cycle that has a read or a write strobe.
module flt_ram_cfg #(
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      busy,
    input  flt_ram_pkg::fault_sel_t   sel_in,
    input  logic [ADDR_W-1:0]         victim_in,
    input  logic [ADDR_W-1:0]         aggr_in,
    output flt_ram_pkg::fault_sel_t   sel_q,
    output logic [ADDR_W-1:0]         victim_q,
    output logic [ADDR_W-1:0]         aggr_q
);
    import flt_ram_pkg::*;

    // load new settings when idle; reset selects fault-free operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '{kind: FK_NONE, val: 1'b0, rise: 1'b0, cond: 1'b0};
            victim_q <= '0;
            aggr_q   <= '0;
        end else if (!busy) begin
            sel_q    <= sel_in;
            victim_q <= victim_in;
            aggr_q   <= aggr_in;
        end
    end

    // settings are frozen across any edge that closes an access cycle
    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(sel_q) && $stable(victim_q) && $stable(aggr_q)));
endmodule

// File: rtl/flt_ram_core.sv
// Module: bit array with the active fault applied. Writes are remapped and
// filtered (decoder swap, transition block, coupling trigger). Reads are
// overridden (stuck, state coupling, bridges, unreachable cell) and then
// registered. Assumes victim and aggressor differ for coupling, bridge and
// decoder kinds.
module flt_ram_core #(
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    we,
    input  logic                    wdata,
    input  logic                    re,
    input  flt_ram_pkg::fault_sel_t sel,
    input  logic [ADDR_W-1:0]       victim,
    input  logic [ADDR_W-1:0]       aggr,
    input  logic                    rnd_bit,
    output logic                    rdata
);
    import flt_ram_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]  mem_q;
    logic [DEPTH-1:0]  mem_d;
    logic [ADDR_W-1:0] wr_tgt;
    logic              wr_ok;
    logic              cpl_trig;
    logic              rd_val;
    logic              vic_bit;
    logic              agg_bit;

    assign vic_bit = mem_q[victim];
    assign agg_bit = mem_q[aggr];

    // write target: the swapped decoder exchanges victim and aggressor
    always_comb begin
        wr_tgt = addr;
        if (sel.kind == FK_DEC_SWP) begin
            if (addr == victim)      wr_tgt = aggr;
            else if (addr == aggr)   wr_tgt = victim;
        end
    end

    // transition block and coupling trigger decisions for this write
    always_comb begin
        wr_ok    = 1'b1;
        cpl_trig = 1'b0;
        if (sel.kind == FK_TRANS && wr_tgt == victim &&
            wdata == sel.val && vic_bit != sel.val)
            wr_ok = 1'b0;
        if ((sel.kind == FK_CPL_INV || sel.kind == FK_CPL_FRC) &&
            wr_tgt == aggr && agg_bit != wdata && wdata == sel.rise)
            cpl_trig = 1'b1;
    end

    // next array contents after the write and any coupled disturbance
    always_comb begin
        mem_d = mem_q;
        if (we) begin
            if (wr_ok) mem_d[wr_tgt] = wdata;
            if (cpl_trig) begin
                if (sel.kind == FK_CPL_INV) mem_d[victim] = ~vic_bit;
                else                        mem_d[victim] = sel.val;
            end
        end
    end

    // one storage flop per cell, cleared by reset
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[i] <= 1'b0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    // value seen by a read, before registering
    always_comb begin
        rd_val = mem_q[addr];
        unique case (sel.kind)
            FK_STUCK:   if (addr == victim) rd_val = sel.val;
            FK_CPL_ST:  if (addr == victim && agg_bit == sel.cond) rd_val = sel.val;
            FK_BR_AND:  if (addr == victim || addr == aggr) rd_val = vic_bit & agg_bit;
            FK_BR_OR:   if (addr == victim || addr == aggr) rd_val = vic_bit | agg_bit;
            FK_DEC_SWP: if (addr == victim) rd_val = rnd_bit;
            default:    rd_val = mem_q[addr];
        endcase
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= 1'b0;
        else if (re) rdata <= rd_val;
    end

    // read data does not move without a read strobe
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));

    // a stuck victim always reads its forced value
    assert_stuck_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (re && sel.kind == FK_STUCK && addr == victim) |=> (rdata == $past(sel.val)));

    // a blocked transition leaves the victim cell untouched
    assert_trans_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel.kind == FK_TRANS && addr == victim && wdata == sel.val &&
         vic_bit != sel.val) |=> $stable(vic_bit));

    // an inverting trigger flips the victim cell
    assert_cpl_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel.kind == FK_CPL_INV && addr == aggr && addr != victim &&
         agg_bit != wdata && wdata == sel.rise) |=> (vic_bit != $past(vic_bit)));

    // ideal kind: a read right after a write to the same cell returns the data
    assert_ideal_wr_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel.kind == FK_NONE) |=> (mem_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/flt_ram_top.sv
// Module: top of the fault-injectable bit RAM. It ties the idle-only fault
// setting register, the pseudo-random source and the faulty array together.
// Assumes a single clock and a synchronous active-low reset.
module flt_ram_top #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    input  logic              mem_wdata,
    input  logic              mem_re,
    output logic              mem_rdata,
    input  logic [3:0]        flt_kind,
    input  logic [ADDR_W-1:0] flt_victim,
    input  logic [ADDR_W-1:0] flt_aggr,
    input  logic              flt_val,
    input  logic              flt_rise,
    input  logic              flt_cond
);
    import flt_ram_pkg::*;

    fault_sel_t        sel_in;
    fault_sel_t        sel_q;
    logic [ADDR_W-1:0] victim_q;
    logic [ADDR_W-1:0] aggr_q;
    logic              rnd_bit;
    logic              busy;

    assign busy   = mem_we | mem_re;
    assign sel_in = '{kind: fault_kind_e'(flt_kind), val: flt_val,
                      rise: flt_rise, cond: flt_cond};

    flt_ram_cfg #(.ADDR_W(ADDR_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .sel_in(sel_in), .victim_in(flt_victim), .aggr_in(flt_aggr),
        .sel_q(sel_q), .victim_q(victim_q), .aggr_q(aggr_q)
    );

    flt_ram_lfsr lfsr_i (
        .clk(clk), .rst_n(rst_n), .rnd_bit(rnd_bit)
    );

    flt_ram_core #(.ADDR_W(ADDR_W)) core_i (
        .clk(clk), .rst_n(rst_n),
        .addr(mem_addr), .we(mem_we), .wdata(mem_wdata), .re(mem_re),
        .sel(sel_q), .victim(victim_q), .aggr(aggr_q),
        .rnd_bit(rnd_bit), .rdata(mem_rdata)
    );
endmodule

// File: tb/flt_ram_top_tb_top.sv
`timescale 1ns/1ps
module flt_ram_top_tb_top;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_we = 1'b0;
    logic          mem_wdata = 1'b0;
    logic          mem_re = 1'b0;
    logic          mem_rdata;
    logic [3:0]    flt_kind = 4'd0;
    logic [AW-1:0] flt_victim = '0;
    logic [AW-1:0] flt_aggr = '0;
    logic          flt_val = 1'b0;
    logic          flt_rise = 1'b0;
    logic          flt_cond = 1'b0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    flt_ram_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .flt_kind(flt_kind), .flt_victim(flt_victim), .flt_aggr(flt_aggr),
        .flt_val(flt_val), .flt_rise(flt_rise), .flt_cond(flt_cond)
    );

    // row: op, requirement number, kind, addr/victim, aggressor, {d,e,c,x}
    typedef struct packed {
        logic [1:0]    op;
        logic [3:0]    rq;
        logic [3:0]    kind;
        logic [AW-1:0] addr;
        logic [AW-1:0] aggr;
        logic [3:0]    fl;
    } vec_t;

    localparam logic [1:0] CF = 2'd0, WR = 2'd1, RD = 2'd2, RW = 2'd3;
    localparam int NV = 62;

    localparam vec_t TBL [NV] = '{
        // R3 ideal storage
        '{CF, 4'd3, 4'd0, 6'd0,  6'd0,  4'b0000},
        '{WR, 4'd3, 4'd0, 6'd3,  6'd0,  4'b1000},
        '{WR, 4'd3, 4'd0, 6'd4,  6'd0,  4'b0000},
        '{RD, 4'd3, 4'd0, 6'd3,  6'd0,  4'b0001},
        '{RD, 4'd3, 4'd0, 6'd4,  6'd0,  4'b0000},
        '{WR, 4'd3, 4'd0, 6'd3,  6'd0,  4'b0000},
        '{RD, 4'd3, 4'd0, 6'd3,  6'd0,  4'b0000},
        // R2 read and write together return old value
        '{RW, 4'd2, 4'd0, 6'd4,  6'd0,  4'b1000},
        '{RD, 4'd2, 4'd0, 6'd4,  6'd0,  4'b0001},
        // R5 stuck at 1 then stuck at 0
        '{CF, 4'd5, 4'd1, 6'd10, 6'd0,  4'b1000},
        '{WR, 4'd5, 4'd0, 6'd10, 6'd0,  4'b0000},
        '{RD, 4'd5, 4'd0, 6'd10, 6'd0,  4'b0001},
        '{RD, 4'd5, 4'd0, 6'd11, 6'd0,  4'b0000},
        '{CF, 4'd5, 4'd1, 6'd10, 6'd0,  4'b0000},
        '{WR, 4'd5, 4'd0, 6'd10, 6'd0,  4'b1000},
        '{RD, 4'd5, 4'd0, 6'd10, 6'd0,  4'b0000},
        // R6 transition: 0->1 blocked, 1->0 allowed
        '{CF, 4'd6, 4'd2, 6'd12, 6'd0,  4'b1000},
        '{WR, 4'd6, 4'd0, 6'd12, 6'd0,  4'b1000},
        '{RD, 4'd6, 4'd0, 6'd12, 6'd0,  4'b0000},
        '{CF, 4'd6, 4'd0, 6'd0,  6'd0,  4'b0000},
        '{WR, 4'd6, 4'd0, 6'd12, 6'd0,  4'b1000},
        '{CF, 4'd6, 4'd2, 6'd12, 6'd0,  4'b1000},
        '{WR, 4'd6, 4'd0, 6'd12, 6'd0,  4'b0000},
        '{RD, 4'd6, 4'd0, 6'd12, 6'd0,  4'b0000},
        // R7 inverting coupling on rising aggressor edge
        '{CF, 4'd7, 4'd3, 6'd20, 6'd21, 4'b0100},
        '{WR, 4'd7, 4'd0, 6'd21, 6'd0,  4'b1000},
        '{RD, 4'd7, 4'd0, 6'd20, 6'd0,  4'b0001},
        '{WR, 4'd7, 4'd0, 6'd21, 6'd0,  4'b1000},
        '{RD, 4'd7, 4'd0, 6'd20, 6'd0,  4'b0001},
        '{WR, 4'd7, 4'd0, 6'd21, 6'd0,  4'b0000},
        '{RD, 4'd7, 4'd0, 6'd20, 6'd0,  4'b0001},
        '{WR, 4'd7, 4'd0, 6'd21, 6'd0,  4'b1000},
        '{RD, 4'd7, 4'd0, 6'd20, 6'd0,  4'b0000},
        // R8 forcing coupling on falling edge, forced value 1
        '{CF, 4'd8, 4'd4, 6'd22, 6'd23, 4'b1000},
        '{WR, 4'd8, 4'd0, 6'd23, 6'd0,  4'b1000},
        '{RD, 4'd8, 4'd0, 6'd22, 6'd0,  4'b0000},
        '{WR, 4'd8, 4'd0, 6'd23, 6'd0,  4'b0000},
        '{RD, 4'd8, 4'd0, 6'd22, 6'd0,  4'b0001},
        '{RD, 4'd8, 4'd0, 6'd23, 6'd0,  4'b0000},
        // R9 state coupling: aggressor at 1 forces victim read to 0
        '{WR, 4'd9, 4'd0, 6'd24, 6'd0,  4'b1000},
        '{CF, 4'd9, 4'd5, 6'd24, 6'd25, 4'b0010},
        '{RD, 4'd9, 4'd0, 6'd24, 6'd0,  4'b0001},
        '{WR, 4'd9, 4'd0, 6'd25, 6'd0,  4'b1000},
        '{RD, 4'd9, 4'd0, 6'd24, 6'd0,  4'b0000},
        '{WR, 4'd9, 4'd0, 6'd25, 6'd0,  4'b0000},
        '{RD, 4'd9, 4'd0, 6'd24, 6'd0,  4'b0001},
        // R10 AND and OR bridges
        '{WR, 4'd10, 4'd0, 6'd26, 6'd0,  4'b1000},
        '{CF, 4'd10, 4'd6, 6'd26, 6'd27, 4'b0000},
        '{RD, 4'd10, 4'd0, 6'd26, 6'd0,  4'b0000},
        '{RD, 4'd10, 4'd0, 6'd27, 6'd0,  4'b0000},
        '{CF, 4'd10, 4'd7, 6'd26, 6'd27, 4'b0000},
        '{RD, 4'd10, 4'd0, 6'd26, 6'd0,  4'b0001},
        '{RD, 4'd10, 4'd0, 6'd27, 6'd0,  4'b0001},
        '{RD, 4'd10, 4'd0, 6'd28, 6'd0,  4'b0000},
        // R11 swapped decode of cells 30 and 31
        '{CF, 4'd11, 4'd8, 6'd30, 6'd31, 4'b0000},
        '{WR, 4'd11, 4'd0, 6'd30, 6'd0,  4'b1000},
        '{RD, 4'd11, 4'd0, 6'd31, 6'd0,  4'b0001},
        '{WR, 4'd11, 4'd0, 6'd31, 6'd0,  4'b1000},
        '{WR, 4'd11, 4'd0, 6'd30, 6'd0,  4'b0000},
        '{CF, 4'd11, 4'd0, 6'd0,  6'd0,  4'b0000},
        '{RD, 4'd11, 4'd0, 6'd30, 6'd0,  4'b0001},
        '{RD, 4'd11, 4'd0, 6'd31, 6'd0,  4'b0000}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // one cycle: drive at a falling edge, look at the result one cycle later
    task automatic apply(input vec_t v);
        mem_we = 1'b0;
        mem_re = 1'b0;
        if (v.op == CF) begin
            flt_kind   = v.kind;
            flt_victim = v.addr;
            flt_aggr   = v.aggr;
            flt_val    = v.fl[3];
            flt_rise   = v.fl[2];
            flt_cond   = v.fl[1];
        end else begin
            mem_addr  = v.addr;
            mem_wdata = v.fl[3];
            mem_we    = (v.op == WR) || (v.op == RW);
            mem_re    = (v.op == RD) || (v.op == RW);
        end
        @(negedge clk);
        mem_we = 1'b0;
        mem_re = 1'b0;
        if (v.op == RD || v.op == RW)
            check($sformatf("R%0d addr %0d", v.rq, v.addr), mem_rdata, v.fl[0]);
    endtask

    task automatic idle_cfg(input logic [3:0] k, input logic [AW-1:0] vc,
                            input logic [AW-1:0] ag, input logic val);
        apply('{CF, 4'd0, k, vc, ag, {val, 3'b000}});
    endtask

    initial begin
        int ones;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata after reset", mem_rdata, 1'b0);
        apply('{RD, 4'd1, 4'd0, 6'd9, 6'd0, 4'b0000});
        apply('{WR, 4'd1, 4'd0, 6'd1, 6'd0, 4'b1000});
        apply('{RD, 4'd1, 4'd0, 6'd1, 6'd0, 4'b0001});

        for (int i = 0; i < NV; i++) apply(TBL[i]);

        // R4 settings presented during an access are ignored
        idle_cfg(4'd0, 6'd0, 6'd0, 1'b0);
        flt_kind = 4'd1; flt_victim = 6'd40; flt_val = 1'b0;
        mem_addr = 6'd40; mem_wdata = 1'b1; mem_we = 1'b1;
        @(negedge clk);
        mem_we = 1'b0;
        flt_kind = 4'd0;
        mem_re = 1'b1;
        @(negedge clk);
        mem_re = 1'b0;
        check("R4 busy-cycle setting ignored", mem_rdata, 1'b1);
        // R4 the same setting on an idle cycle acts from the next cycle
        idle_cfg(4'd1, 6'd40, 6'd0, 1'b0);
        apply('{RD, 4'd4, 4'd0, 6'd40, 6'd0, 4'b0000});
        idle_cfg(4'd0, 6'd0, 6'd0, 1'b0);
        apply('{RD, 4'd4, 4'd0, 6'd40, 6'd0, 4'b0001});

        // R11 unreachable cell read gives both values over many reads
        idle_cfg(4'd8, 6'd30, 6'd31, 1'b0);
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            mem_addr = 6'd30;
            mem_re = 1'b1;
            @(negedge clk);
            mem_re = 1'b0;
            if (mem_rdata) ones++;
        end
        check("R11 random read shows a 1", (ones > 0) ? 1'b1 : 1'b0, 1'b1);
        check("R11 random read shows a 0", (ones < 40) ? 1'b1 : 1'b0, 1'b1);

        // R1 a second reset clears cells and the fault selection
        rst_n = 1'b0;
        flt_kind = 4'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata after second reset", mem_rdata, 1'b0);
        apply('{RD, 4'd1, 4'd0, 6'd24, 6'd0, 4'b0000});
        apply('{RD, 4'd1, 4'd0, 6'd3, 6'd0, 4'b0000});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule